// File: doc/BRIEF.md
# Nine-Level Staircase Gate Sequencer

This block drives the eight gates of a single-phase nine-level inverter built from a level-selection stage (four switches, one per output magnitude) and a four-switch polarity bridge. A free-running phase accumulator marks out one fundamental period. Its position is folded into the first quarter wave and compared with four programmed switching angles. The count of angles already passed gives the output magnitude, from 0 to 4. The half of the period that the phase is in gives the sign. The angles are worked out offline, for example by a harmonic-elimination search, and are written into the block through a small register write port.

Angle writes go into a shadow set. That set is checked and copied into the working set only at the wrap of the phase accumulator, or on any clock edge while the block is disabled, so a running staircase never uses a mix of old and new angles. A set that is out of order, or that reaches a quarter period, is refused: the working set stays as it was and an error flag is raised. Every change of the applied level passes through a programmable dead time in which all gates are off, so no switch turns on while another is still turning off.

With the default 32-bit accumulator, the phase word is its top 16 bits, and one full period equals 65536 phase units. A 100 MHz clock with a step word of 2147 gives about 50 Hz.

Top module: `msq_gate_seq`

## Requirements
- R1: On each clock edge with `en_i` high, the phase accumulator advances by `step_i` modulo 2^32. With `en_i` low it is held at 0 and the target level is 0.
- R2: The phase word p is the accumulator's top 16 bits. Take r = p[14:0]; if r >= 16384, replace r with 32767 - r. The target magnitude is the number of working angles a_k with a_k <= r. The target is negative when p[15] = 1. `lvl_o` carries the applied level as 4-bit two's complement.
- R3: For an applied level of magnitude k (1..4), only `lvl_sw_o[k-1]` is set. For level 0, all bits of `lvl_sw_o` are 0.
- R4: The bridge bits are `brg_o[0]`=T1, `brg_o[1]`=T2, `brg_o[2]`=T3, `brg_o[3]`=T4. A positive level drives 4'b0101 and a negative level drives 4'b1010.
- R5: Level 0 shorts the load through the bridge pair of the most recent nonzero polarity (4'b1010 after a negative level, otherwise 4'b0101). The level switches are all off.
- R6: With `dead_i` = D > 0, a difference between target and applied level turns all eight gates off for exactly D cycles. After that, the target current at that moment is applied, and `lvl_o` keeps the old level until then. With D = 0 the target is applied on the next edge.
- R7: A write stores `wr_data_i` into shadow slot `wr_idx_i` and marks the shadow set pending. The pending set is committed on the edge where the accumulator wraps, or on any edge while `en_i` is low. A write on the commit edge waits for the next commit.
- R8: A committed set is refused unless a0 < a1 < a2 < a3 < 16384. On refusal the working set is kept and `ang_err_o` is set. An accepted commit clears `ang_err_o`.
- R9: After reset the working and shadow angles are 1791, 3710, 6992 and 10994, the level is 0, `brg_o` is 4'b0101, `lvl_sw_o` is 0 and `ang_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Runs the phase accumulator and the staircase |
| step_i | input | 32 | Phase increment per clock |
| wr_en_i | input | 1 | Angle write strobe |
| wr_idx_i | input | 2 | Shadow angle slot to write |
| wr_data_i | input | 16 | Angle value in phase units |
| dead_i | input | 8 | Dead time in clock cycles |
| lvl_sw_o | output | 4 | Level-selection switch gates, bit k-1 for magnitude k |
| brg_o | output | 4 | Polarity bridge gates T1..T4 in bits 0..3 |
| lvl_o | output | 4 | Applied output level, signed |
| ang_err_o | output | 1 | Last committed angle set was refused |

## Verification
Two situations are hard to bring about from the ports. The first is an angle write that lands on the very edge where the accumulator wraps. The second is a target that moves again while a dead time is still running. For the first, the stimulus predicts the wrap edge from the step word and fires a write exactly there. It also mixes in random mid-period writes, including ones that form unordered sets. For the second, the step words are large, so the level changes every few cycles, and dead times of 1 to 3 cycles are used so that dead windows overlap target changes.

// File: rtl/msq_pkg.sv
package msq_pkg;
    localparam int N_UNITS = 4;
    localparam int ANG_W   = 16;
    localparam int IDX_W   = $clog2(N_UNITS);
    localparam int LVL_W   = $clog2(N_UNITS + 1) + 1;
    localparam int BRG_N   = 4;

    localparam logic [ANG_W-1:0] QUARTER = {2'b01, {(ANG_W-2){1'b0}}};
    localparam logic [ANG_W-1:0] HALF_M1 = {1'b0, {(ANG_W-1){1'b1}}};

    localparam logic [BRG_N-1:0] BRG_POS = 4'b0101;
    localparam logic [BRG_N-1:0] BRG_NEG = 4'b1010;

    typedef logic [ANG_W-1:0]        ang_t;
    typedef ang_t [N_UNITS-1:0]      ang_set_t;
    typedef logic signed [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic [N_UNITS-1:0] lvl_sw;
        logic [BRG_N-1:0]   brg;
    } gate_t;

    localparam ang_set_t DEFAULT_ANGLES = {16'd10994, 16'd6992, 16'd3710, 16'd1791};

    function automatic logic set_ok(ang_set_t s);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < N_UNITS; k++) begin
            if (s[k] >= QUARTER) ok = 1'b0;
        end
        for (int k = 1; k < N_UNITS; k++) begin
            if (s[k] <= s[k-1]) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic gate_t decode(lvl_t lv, logic neg_pair, logic off);
        gate_t g;
        lvl_t  mag;
        g   = '0;
        mag = lv[LVL_W-1] ? -lv : lv;
        if (!off) begin
            for (int k = 1; k <= N_UNITS; k++) begin
                if (mag == lvl_t'(k)) g.lvl_sw[k-1] = 1'b1;
            end
            if (lv[LVL_W-1])   g.brg = BRG_NEG;
            else if (lv != '0) g.brg = BRG_POS;
            else               g.brg = neg_pair ? BRG_NEG : BRG_POS;
        end
        return g;
    endfunction
endpackage

// File: rtl/msq_phase.sv
module msq_phase #(
    parameter int PH_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [PH_W-1:0] step,
    output logic [PH_W-1:0] phase_q,
    output logic            wrap
);
    logic [PH_W:0] sum;

    assign sum  = {1'b0, phase_q} + {1'b0, step};
    assign wrap = en & sum[PH_W];

    always_ff @(posedge clk) begin
        if (rst)       phase_q <= '0;
        else if (!en)  phase_q <= '0;
        else           phase_q <= sum[PH_W-1:0];
    end
endmodule

// File: rtl/msq_angles.sv
module msq_angles import msq_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ang_t             wr_data,
    input  logic             commit,
    output ang_set_t         act_q,
    output logic             err_q
);
    ang_set_t shadow_q;
    logic     pend_q;
    logic     take;

    assign take = commit & pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= DEFAULT_ANGLES;
            act_q    <= DEFAULT_ANGLES;
            pend_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (take) begin
                if (set_ok(shadow_q)) begin
                    act_q <= shadow_q;
                    err_q <= 1'b0;
                end else begin
                    err_q <= 1'b1;
                end
            end
            if (wr_en) shadow_q[wr_idx] <= wr_data;
            pend_q <= (pend_q & ~commit) | wr_en;
        end
    end
endmodule

// File: rtl/msq_slicer.sv
module msq_slicer import msq_pkg::*; (
    input  logic     en,
    input  ang_t     pos,
    input  ang_set_t act,
    output lvl_t     tgt
);
    ang_t               half_pos;
    ang_t               folded;
    logic [N_UNITS-1:0] hit;
    logic [LVL_W-1:0]   cnt;

    assign half_pos = {1'b0, pos[ANG_W-2:0]};
    assign folded   = (half_pos < QUARTER) ? half_pos : (HALF_M1 - half_pos);

    for (genvar k = 0; k < N_UNITS; k++) begin : g_cmp
        assign hit[k] = (folded >= act[k]);
    end

    always_comb begin
        cnt = '0;
        for (int k = 0; k < N_UNITS; k++) begin
            cnt = cnt + LVL_W'(hit[k]);
        end
        if (!en)                tgt = '0;
        else if (pos[ANG_W-1])  tgt = -$signed(cnt);
        else                    tgt = $signed(cnt);
    end
endmodule

// File: rtl/msq_gate_fsm.sv
module msq_gate_fsm import msq_pkg::*; #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  lvl_t            tgt,
    input  logic [DT_W-1:0] dead,
    output lvl_t            cur_q,
    output gate_t           gates
);
    logic            in_dt_q;
    logic [DT_W-1:0] cnt_q;
    logic            neg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            in_dt_q <= 1'b0;
            cnt_q   <= '0;
            neg_q   <= 1'b0;
        end else if (in_dt_q) begin
            if (cnt_q == '0) begin
                in_dt_q <= 1'b0;
                cur_q   <= tgt;
                if (tgt != '0) neg_q <= tgt[LVL_W-1];
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (tgt != cur_q) begin
            if (dead == '0) begin
                cur_q <= tgt;
                if (tgt != '0) neg_q <= tgt[LVL_W-1];
            end else begin
                in_dt_q <= 1'b1;
                cnt_q   <= dead - 1'b1;
            end
        end
    end

    assign gates = decode(cur_q, neg_q, in_dt_q);
endmodule

// File: rtl/msq_gate_seq.sv
module msq_gate_seq import msq_pkg::*; #(
    parameter int PH_W = 32,
    parameter int DT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_i,
    input  logic [PH_W-1:0]         step_i,
    input  logic                    wr_en_i,
    input  logic [IDX_W-1:0]        wr_idx_i,
    input  logic [ANG_W-1:0]        wr_data_i,
    input  logic [DT_W-1:0]         dead_i,
    output logic [N_UNITS-1:0]      lvl_sw_o,
    output logic [BRG_N-1:0]        brg_o,
    output logic signed [LVL_W-1:0] lvl_o,
    output logic                    ang_err_o
);
    logic [PH_W-1:0] phase;
    logic            wrap;
    ang_set_t        act;
    lvl_t            tgt;
    lvl_t            cur;
    gate_t           gates;

    msq_phase #(.PH_W(PH_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .en      (en_i),
        .step    (step_i),
        .phase_q (phase),
        .wrap    (wrap)
    );

    msq_angles u_angles (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_idx  (wr_idx_i),
        .wr_data (wr_data_i),
        .commit  (wrap | ~en_i),
        .act_q   (act),
        .err_q   (ang_err_o)
    );

    msq_slicer u_slicer (
        .en  (en_i),
        .pos (phase[PH_W-1 -: ANG_W]),
        .act (act),
        .tgt (tgt)
    );

    msq_gate_fsm #(.DT_W(DT_W)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .tgt   (tgt),
        .dead  (dead_i),
        .cur_q (cur),
        .gates (gates)
    );

    assign lvl_o    = cur;
    assign lvl_sw_o = gates.lvl_sw;
    assign brg_o    = gates.brg;
endmodule

// File: rtl/msq_gate_seq_chk.sv
module msq_gate_seq_chk import msq_pkg::*; #(
    parameter int DT_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic [DT_W-1:0]         dead_i,
    input logic [N_UNITS-1:0]      lvl_sw_o,
    input logic [BRG_N-1:0]        brg_o,
    input logic signed [LVL_W-1:0] lvl_o
);
    logic [LVL_W-1:0]           mag;
    logic [N_UNITS+BRG_N-1:0]   all_g;

    assign mag   = lvl_o[LVL_W-1] ? LVL_W'(-lvl_o) : LVL_W'(lvl_o);
    assign all_g = {lvl_sw_o, brg_o};

    AST_BRG_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (brg_o == 4'b0000) || (brg_o == BRG_POS) || (brg_o == BRG_NEG)); // R4
    AST_LVLSW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lvl_sw_o)); // R3
    AST_LVLSW_MATCH: assert property (@(posedge clk) disable iff (rst)
        (lvl_sw_o != '0) |-> (lvl_sw_o == (N_UNITS'(1) << (mag - 1'b1)))); // R3
    AST_POS_PAIR: assert property (@(posedge clk) disable iff (rst)
        (lvl_o > 0) |-> (brg_o != BRG_NEG)); // R4
    AST_NEG_PAIR: assert property (@(posedge clk) disable iff (rst)
        (lvl_o < 0) |-> (brg_o != BRG_POS)); // R4
    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
        ((dead_i != '0) && (all_g != '0)) |=> ((all_g == '0) || $stable(all_g))); // R6
endmodule

bind msq_gate_seq msq_gate_seq_chk #(.DT_W(DT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dead_i   (dead_i),
    .lvl_sw_o (lvl_sw_o),
    .brg_o    (brg_o),
    .lvl_o    (lvl_o)
);

// File: tb/msq_gate_seq_bench.sv
module msq_gate_seq_bench;
    import msq_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0;
    logic [31:0] step_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_idx_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [7:0]  dead_i = '0;
    logic [3:0]  lvl_sw_o;
    logic [3:0]  brg_o;
    logic signed [3:0] lvl_o;
    logic        ang_err_o;

    int checks = 0;
    int errors = 0;
    string ctx = "R9 reset";
    logic mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msq_gate_seq u_msq_gate_seq (
        .clk(clk), .rst(rst), .en_i(en_i), .step_i(step_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .dead_i(dead_i), .lvl_sw_o(lvl_sw_o), .brg_o(brg_o),
        .lvl_o(lvl_o), .ang_err_o(ang_err_o)
    );

    // Reference model built from the requirements
    logic [31:0] m_phase;
    ang_set_t    m_act, m_sh;
    logic        m_pend, m_err, m_indt, m_neg;
    lvl_t        m_cur;
    logic [7:0]  m_cnt;

    function automatic lvl_t ref_target(logic [31:0] ph, ang_set_t a, logic en);
        int r;
        int c;
        if (!en) return '0;
        r = int'(ph[30:16]);
        if (r >= 16384) r = 32767 - r;
        c = 0;
        for (int k = 0; k < 4; k++) if (int'(a[k]) <= r) c++;
        return ph[31] ? lvl_t'(-c) : lvl_t'(c);
    endfunction

    function automatic logic ref_valid(ang_set_t a);
        return (a[0] < a[1]) && (a[1] < a[2]) && (a[2] < a[3]) && (int'(a[3]) < 16384);
    endfunction

    function automatic logic [7:0] ref_gates(lvl_t lv, logic neg, logic off);
        int m;
        logic [3:0] sw;
        logic [3:0] b;
        if (off) return 8'h00;
        m  = (lv < 0) ? -int'(lv) : int'(lv);
        sw = (m == 0) ? 4'b0000 : 4'(1 << (m - 1));
        if (lv > 0)      b = 4'b0101;
        else if (lv < 0) b = 4'b1010;
        else             b = neg ? 4'b1010 : 4'b0101;
        return {sw, b};
    endfunction

    always @(posedge clk) begin
        lvl_t t;
        logic wrp, com;
        if (rst) begin
            m_phase <= '0; m_act <= DEFAULT_ANGLES; m_sh <= DEFAULT_ANGLES;
            m_pend <= 1'b0; m_err <= 1'b0; m_indt <= 1'b0; m_neg <= 1'b0;
            m_cur <= '0; m_cnt <= '0;
        end else begin
            t   = ref_target(m_phase, m_act, en_i);
            wrp = en_i && ((33'(m_phase) + 33'(step_i)) >= 33'h1_0000_0000);
            com = wrp || !en_i;
            if (com && m_pend) begin
                if (ref_valid(m_sh)) begin m_act <= m_sh; m_err <= 1'b0; end
                else m_err <= 1'b1;
            end
            if (wr_en_i) m_sh[wr_idx_i] <= wr_data_i;
            m_pend  <= (m_pend && !com) || wr_en_i;
            m_phase <= en_i ? m_phase + step_i : '0;
            if (m_indt) begin
                if (m_cnt == 0) begin
                    m_indt <= 1'b0; m_cur <= t;
                    if (t != 0) m_neg <= (t < 0);
                end else m_cnt <= m_cnt - 1;
            end else if (t != m_cur) begin
                if (dead_i == 0) begin
                    m_cur <= t;
                    if (t != 0) m_neg <= (t < 0);
                end else begin
                    m_indt <= 1'b1; m_cnt <= dead_i - 1;
                end
            end
        end
    end

    task automatic check(logic ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && !rst) begin
            logic [7:0] eg;
            eg = ref_gates(m_cur, m_neg, m_indt);
            check(lvl_o == m_cur, $sformatf("R1/R2 level [%s]", ctx), int'(lvl_o), int'(m_cur));
            check(lvl_sw_o == eg[7:4], m_indt ? $sformatf("R6 level gates [%s]", ctx) :
                  $sformatf("R3 level gates [%s]", ctx), int'(lvl_sw_o), int'(eg[7:4]));
            check(brg_o == eg[3:0], m_indt ? $sformatf("R6 bridge [%s]", ctx) :
                  (m_cur == 0) ? $sformatf("R5 bridge [%s]", ctx) : $sformatf("R4 bridge [%s]", ctx),
                  int'(brg_o), int'(eg[3:0]));
            check(ang_err_o == m_err, $sformatf("R8 error flag [%s]", ctx), int'(ang_err_o), int'(m_err));
        end
    end

    task automatic write_angle(int idx, int val);
        wr_en_i = 1'b1; wr_idx_i = 2'(idx); wr_data_i = 16'(val);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic load_set(int a0, int a1, int a2, int a3);
        write_angle(0, a0); write_angle(1, a1); write_angle(2, a2); write_angle(3, a3);
        @(negedge clk);
    endtask

    task automatic run_random(int cycles, int wr_rate);
        for (int i = 0; i < cycles; i++) begin
            if (($urandom % wr_rate) == 0) begin
                wr_en_i = 1'b1; wr_idx_i = 2'($urandom % 4);
                wr_data_i = 16'($urandom % 16384);
            end else wr_en_i = 1'b0;
            @(negedge clk);
        end
        wr_en_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 300000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4417));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state at the ports
        check(lvl_o == 0, "R9 reset level", int'(lvl_o), 0);
        check(lvl_sw_o == 4'b0000, "R9 reset level gates", int'(lvl_sw_o), 0);
        check(brg_o == 4'b0101, "R9 reset bridge", int'(brg_o), 5);
        check(ang_err_o == 1'b0, "R9 reset error", int'(ang_err_o), 0);
        mon_on = 1'b1;

        // R9 defaults in use, R1 phase sweep with no dead time
        ctx = "R1 default angles";
        step_i = 32'h0080_0000; en_i = 1'b1;
        repeat (1100) @(negedge clk);

        // R8: refused set while disabled
        ctx = "R8 bad set";
        en_i = 1'b0; dead_i = 8'd2;
        repeat (6) @(negedge clk);
        load_set(100, 50, 200, 300);
        check(ang_err_o == 1'b1, "R8 unordered set flagged", int'(ang_err_o), 1);
        check(lvl_o == 0, "R1 disabled level", int'(lvl_o), 0);
        load_set(1000, 2000, 3000, 16384);
        check(ang_err_o == 1'b1, "R8 quarter reached flagged", int'(ang_err_o), 1);
        ctx = "R8 kept set running";
        en_i = 1'b1; step_i = 32'h00A0_0000;
        repeat (900) @(negedge clk);

        // R8 clear and R6 dead times
        en_i = 1'b0;
        repeat (8) @(negedge clk);
        load_set(2000, 5000, 8000, 12000);
        check(ang_err_o == 1'b0, "R8 accepted set clears flag", int'(ang_err_o), 0);
        for (int d = 1; d <= 3; d++) begin
            ctx = "R6 dead time";
            dead_i = 8'(d); en_i = 1'b1; step_i = 32'h0100_0000 + 32'($urandom % 32'h0040_0000);
            repeat (700) @(negedge clk);
        end

        // R7: write landing exactly on the wrap edge
        ctx = "R7 write on wrap";
        dead_i = 8'd1; step_i = 32'h0080_0000;
        for (int n = 0; n < 6; n++) begin
            while (!((33'(m_phase) + 33'(step_i)) >= 33'h1_0000_0000)) @(negedge clk);
            write_angle(n % 4, 1500 + 2500 * (n % 4) + n);
            repeat (300) @(negedge clk);
        end

        // R7 mid-period writes mixed with random steps and dead times
        for (int s = 0; s < 12; s++) begin
            ctx = "R7 random writes";
            dead_i = 8'($urandom % 4);
            step_i = 32'h0080_0000 + 32'($urandom % 32'h0100_0000);
            run_random(1200, 40);
            if ((s % 4) == 3) begin
                ctx = "R1 disable";
                en_i = 1'b0;
                repeat (10) @(negedge clk);
                load_set(1791, 3710, 6992, 10994);
                en_i = 1'b1;
            end
        end

        mon_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule